// File: doc/BRIEF.md
# Wide-Register Microcoded Sequencer

This block is a small instruction sequencer that steps through a stored microprogram. The program works on a file of 32 registers, each 256 bits wide. A host reaches the register file, the program store and three control words through one memory-mapped port with 32-bit data. The host fills registers one 32-bit word at a time, writes the program, sets an enable bit and starts the run with a program length. It then polls a status word until the busy bit drops.

The instruction set is a set of whole-register logic operations. It can copy a register or a built-in constant, XOR two values, mask a value with a one-bit selector, extract a single bit, shift left by one and subtract. It can also branch when a full 256-bit value is zero, and it can stop. With these operations the program runs a constant-time conditional-swap ladder: the swap is done by a mask and XOR sequence, so the flow of control never depends on the data. Each instruction takes one clock cycle. A run that walks past its programmed length, or meets an opcode that does not exist, stops with an error flag set.

Top module: `wide_seq_engine`

## Requirements
- R1: Register r, word w (bits 32w+31..32w) sits at byte address r*32 + w*4 in region 0x000-0x3FF. It can be written and read back as a 32-bit word, and the other words are left unchanged. Program word i sits at 0x400 + i*4, for 192 words.
- R2: The enable word at 0x800 holds bit 0. A write to the control word at 0x804 with bit 0 set starts a run, with the length taken from bits 15:8. The write is ignored when enable is 0. Bit 0 of status (0x808) reads 1 from the start until the run stops.
- R3: Copy (opcode 1) writes operand A to the destination. Operand codes 0-31 select a register. Code 32+k selects constant k, where k=0 gives 0, 1 gives 1, 5 gives 5, 6 gives 10, 7 gives 20, 8 gives 50, 9 gives 100, 10 gives 254, and any other k gives 0.
- R4: XOR (opcode 2) writes A xor B over all 256 bits.
- R5: Mask (opcode 3) writes B when bit 0 of A is 1, and writes all zeros when it is 0. A mask and XOR sequence swaps two registers only when the selector is 1.
- R6: Bit extract (opcode 4) writes bit 254 of A into bit 0 and clears every other bit. Shift (opcode 5) writes A shifted left by one, so bit 255 is lost and bit 0 becomes 0.
- R7: Subtract (opcode 6) writes A minus B, modulo 2^256.
- R8: Branch (opcode 7) adds its signed offset to the program counter when all 256 bits of A are zero, and otherwise steps to the next instruction. A as constant 0 always branches. A nonzero value held only in bit 255 does not branch.
- R9: A loop whose counter starts at 254 and is decremented after each non-zero test runs its body 255 times. A counter that starts at 0 runs the body once.
- R10: If the program counter reaches the length without a finish, or an undefined opcode (8-63) is met, the run stops and status bit 1 is set. That bit is cleared by the next start.
- R11: While busy, host writes to registers and to the program store are ignored. Host reads during the run return the current contents.
- R12: Instruction fields are: opcode in bits 5:0, operand A in 11:6, operand B in 17:12, destination register in 22:18, and a two's-complement branch offset in 31:23. Finish is opcode 0, and it stops the run with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe, one cycle per word |
| host_addr | input | 12 | Byte address of the word (word aligned) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr, combinational |

## Verification
A wrong program counter or branch decision shows up as a wrong loop count. The low word of an accumulator decremented once per pass then differs from 2^32-255 when the run ends, roughly a thousand cycles after the start. A datapath slip appears one cycle after the instruction, in the destination register that the host reads back, and each operation is run against its own patterned operands. Errors in the busy or error flags show up in the status word on the first poll after the stop, and a lockout that fails lets a mid-run host write change data that is read back after the run.

// File: rtl/wide_seq_engine.sv
module wide_seq_engine #(
  parameter int NREGS      = 32,
  parameter int REG_W      = 256,
  parameter int WORD_W     = 32,
  parameter int PROG_DEPTH = 192,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata
);
  localparam int WPR    = REG_W / WORD_W;
  localparam int RIDX_W = $clog2(NREGS);
  localparam int WSEL_W = $clog2(WPR);
  localparam int SPAN_W = RIDX_W + WSEL_W + 2;
  localparam int PIDX_W = SPAN_W - 2;
  localparam int PC_W   = $clog2(PROG_DEPTH) + 1;
  localparam int LEN_W  = $clog2(PROG_DEPTH + 1);

  localparam logic [5:0] OP_FIN = 6'd0, OP_PSA = 6'd1, OP_XOR = 6'd2, OP_MSK = 6'd3,
                         OP_XBT = 6'd4, OP_SHL = 6'd5, OP_SUB = 6'd6, OP_BRZ = 6'd7;

  logic [REG_W-1:0]  rf   [NREGS];
  logic [31:0]       prog [PROG_DEPTH];
  logic              enable_q, busy_q, err_q;
  logic [PC_W-1:0]   pc_q;
  logic [LEN_W-1:0]  len_q;

  wire aligned = host_addr[1:0] == 2'b00;
  wire [ADDR_W-SPAN_W-1:0] region = host_addr[ADDR_W-1:SPAN_W];
  wire hit_rf = aligned && region == '0;
  wire hit_pm = aligned && region == (ADDR_W-SPAN_W)'(1);
  wire hit_ct = aligned && region == (ADDR_W-SPAN_W)'(2);
  wire [RIDX_W-1:0] ridx = host_addr[SPAN_W-1 -: RIDX_W];
  wire [WSEL_W-1:0] wsel = host_addr[WSEL_W+1:2];
  wire [PIDX_W-1:0] pidx = host_addr[SPAN_W-1:2];
  wire pidx_ok = int'(pidx) < PROG_DEPTH;

  wire in_range = pc_q < PC_W'(len_q);
  wire [31:0] instr = in_range ? prog[pc_q[PC_W-2:0]] : 32'd0;
  wire [5:0] op     = instr[5:0];
  wire [5:0] a_code = instr[11:6];
  wire [5:0] b_code = instr[17:12];
  wire [4:0] dst    = instr[22:18];
  wire [8:0] off    = instr[31:23];

  function automatic logic [REG_W-1:0] kval(input logic [4:0] k);
    case (k)
      5'd1:    kval = REG_W'(1);
      5'd5:    kval = REG_W'(5);
      5'd6:    kval = REG_W'(10);
      5'd7:    kval = REG_W'(20);
      5'd8:    kval = REG_W'(50);
      5'd9:    kval = REG_W'(100);
      5'd10:   kval = REG_W'(254);
      default: kval = '0;
    endcase
  endfunction

  logic [REG_W-1:0] va, vb, res;
  logic             wr_op;
  assign va = a_code[5] ? kval(a_code[4:0]) : rf[a_code[RIDX_W-1:0]];
  assign vb = b_code[5] ? kval(b_code[4:0]) : rf[b_code[RIDX_W-1:0]];

  always_comb begin
    res   = '0;
    wr_op = 1'b1;
    case (op)
      OP_PSA:  res = va;
      OP_XOR:  res = va ^ vb;
      OP_MSK:  res = va[0] ? vb : '0;
      OP_XBT:  res[0] = va[REG_W-2];
      OP_SHL:  res = va << 1;
      OP_SUB:  res = va - vb;
      default: wr_op = 1'b0;
    endcase
  end

  wire ex_wr     = busy_q && in_range && wr_op;
  wire op_known  = op <= OP_BRZ;
  wire [LEN_W-1:0] len_req = host_wdata[8 +: LEN_W];
  wire start_req = host_wr && hit_ct && pidx == PIDX_W'(1) && host_wdata[0] && enable_q && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (ex_wr) begin
      rf[dst[RIDX_W-1:0]] <= res;
    end else if (host_wr && hit_rf && !busy_q) begin
      rf[ridx][wsel*WORD_W +: WORD_W] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PROG_DEPTH; i++) prog[i] <= '0;
    end else if (host_wr && hit_pm && pidx_ok && !busy_q) begin
      prog[pidx] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      pc_q     <= '0;
      len_q    <= '0;
    end else begin
      if (host_wr && hit_ct && pidx == '0) enable_q <= host_wdata[0];
      if (start_req) begin
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        pc_q   <= '0;
        len_q  <= (len_req > LEN_W'(PROG_DEPTH)) ? LEN_W'(PROG_DEPTH) : len_req;
      end else if (busy_q) begin
        if (!in_range || !op_known) begin
          busy_q <= 1'b0;
          err_q  <= 1'b1;
        end else if (op == OP_FIN) begin
          busy_q <= 1'b0;
        end else if (op == OP_BRZ && va == '0) begin
          pc_q <= pc_q + PC_W'($signed(off));
        end else begin
          pc_q <= pc_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (hit_rf) host_rdata = rf[ridx][wsel*WORD_W +: WORD_W];
    else if (hit_pm && pidx_ok) host_rdata = prog[pidx];
    else if (hit_ct) begin
      case (pidx)
        PIDX_W'(0): host_rdata = WORD_W'(enable_q);
        PIDX_W'(1): host_rdata = WORD_W'(len_q) << 8;
        PIDX_W'(2): host_rdata = WORD_W'({err_q, busy_q});
        default:    host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wide_seq_engine_chk.sv
module wide_seq_engine_chk #(
  parameter int PC_W       = 9,
  parameter int ADDR_W     = 12,
  parameter int PROG_DEPTH = 192,
  parameter int SPAN_W     = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              err,
  input logic              enable,
  input logic              in_range,
  input logic              a_zero,
  input logic              host_wr,
  input logic [PC_W-1:0]   pc,
  input logic [5:0]        op,
  input logic [8:0]        off,
  input logic [ADDR_W-1:0] host_addr,
  input logic [31:0]       prog [PROG_DEPTH]
);
  wire [SPAN_W-3:0] pidx = host_addr[SPAN_W-1:2];
  wire pm_hit = host_addr[1:0] == 2'b00 && host_addr[ADDR_W-1:SPAN_W] == (ADDR_W-SPAN_W)'(1)
                && int'(pidx) < PROG_DEPTH;

  logic             locked_q;
  logic [SPAN_W-3:0] pidx_q;
  logic [31:0]      prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      pidx_q   <= '0;
      prev_q   <= '0;
    end else begin
      locked_q <= busy && host_wr && pm_hit;
      pidx_q   <= pidx;
      prev_q   <= pm_hit ? prog[pidx] : 32'd0;
    end
  end

  a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable));
  a_r2_pc_zero_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> pc == '0);
  a_r10_error_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  a_r10_overrun_stops: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !in_range |=> !busy && err);
  a_r12_fin_clean_stop: assert property (@(posedge clk) disable iff (!rst_n)
    busy && in_range && op == 6'd0 |=> !busy && !err);
  a_r8_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
    busy && in_range && op == 6'd7 && a_zero |=> pc == $past(pc + PC_W'($signed(off))));
  a_r11_prog_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> prog[pidx_q] == prev_q);
endmodule

bind wide_seq_engine wide_seq_engine_chk #(
  .PC_W(PC_W), .ADDR_W(ADDR_W), .PROG_DEPTH(PROG_DEPTH), .SPAN_W(SPAN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .err(err_q), .enable(enable_q),
  .in_range(in_range), .a_zero(va == '0), .host_wr(host_wr), .pc(pc_q),
  .op(op), .off(off), .host_addr(host_addr), .prog(prog)
);

// File: tb/sim_wide_seq_engine.sv
module sim_wide_seq_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;

  always #5 clk = ~clk;

  wide_seq_engine u0 (.clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
                      .host_wdata(host_wdata), .host_rdata(host_rdata));

  localparam logic [11:0] A_PROG = 12'h400, A_EN = 12'h800, A_CTL = 12'h804, A_STS = 12'h808;

  // {opcode, operand A, operand B, destination}
  localparam logic [22:0] VEC [13] = '{
    {6'd1, 6'd1,  6'd0,  5'd12}, {6'd1, 6'd42, 6'd0,  5'd13}, {6'd1, 6'd39, 6'd0,  5'd14},
    {6'd1, 6'd35, 6'd0,  5'd15}, {6'd2, 6'd1,  6'd2,  5'd16}, {6'd3, 6'd3,  6'd2,  5'd17},
    {6'd3, 6'd4,  6'd2,  5'd18}, {6'd4, 6'd5,  6'd0,  5'd19}, {6'd4, 6'd6,  6'd0,  5'd20},
    {6'd5, 6'd6,  6'd0,  5'd21}, {6'd6, 6'd4,  6'd33, 5'd22}, {6'd6, 6'd2,  6'd1,  5'd23},
    {6'd2, 6'd1,  6'd41, 5'd24}
  };

  int checks = 0, fails = 0;
  logic [255:0] m [8];

  task automatic chk(input logic ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wreg(input int r, input logic [255:0] v);
    for (int w = 0; w < 8; w++) wr(12'(r * 32 + w * 4), v[w*32 +: 32]);
  endtask

  task automatic rreg(input int r, output logic [255:0] v);
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      rd(12'(r * 32 + w * 4), d);
      v[w*32 +: 32] = d;
    end
  endtask

  task automatic pput(input int i, input logic [31:0] d);
    wr(A_PROG + 12'(i * 4), d);
  endtask

  task automatic run(input int len, output logic [31:0] st);
    wr(A_CTL, 32'((len << 8) | 1));
    for (int n = 0; n < 5000; n++) begin
      rd(A_STS, st);
      if (!st[0]) break;
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [5:0] a, input logic [5:0] b,
                                      input logic [4:0] d, input logic [8:0] off);
    return {off, d, b, a, op};
  endfunction

  function automatic logic [255:0] konst(input int k);
    case (k) // R3 constant table
      1: return 256'd1;   5: return 256'd5;   6: return 256'd10;  7: return 256'd20;
      8: return 256'd50;  9: return 256'd100; 10: return 256'd254;
      default: return '0;
    endcase
  endfunction

  function automatic logic [255:0] opnd(input logic [5:0] c);
    return c[5] ? konst(int'(c[4:0])) : m[c[2:0]];
  endfunction

  function automatic logic [255:0] model(input logic [5:0] op, input logic [5:0] a, input logic [5:0] b);
    logic [255:0] x = opnd(a), y = opnd(b);
    case (op)
      6'd1: return x;
      6'd2: return x ^ y;
      6'd3: return x[0] ? y : '0;
      6'd4: return {255'd0, x[254]};
      6'd5: return {x[254:0], 1'b0};
      6'd6: return x - y;
      default: return '0;
    endcase
  endfunction

  function automatic string tagof(input logic [5:0] op);
    case (op)
      6'd1: return "R3/R12";  6'd2: return "R4/R12";  6'd3: return "R5/R12";
      6'd4, 6'd5: return "R6/R12";  default: return "R7/R12";
    endcase
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0]  st, d;
    logic [255:0] v;
    m[0] = '0;
    m[1] = 256'h0123456789ABCDEFFEDCBA9876543210A5A50F0F5A5AF0F013579BDF2468ACE0;
    m[2] = 256'hDEADBEEFCAFEF00D0BADC0DEFACEB00C800000017FFFFFFE0000FFFFFFFF0000;
    m[3] = 256'd1;
    m[4] = 256'd0;
    m[5] = (256'd1 << 254) | 256'd2;
    m[6] = (256'd1 << 255) | 256'd3;
    m[7] = m[1];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(A_STS, st); chk(st == 0, "R2 reset status", 256'(st), 0);
    rd(A_EN, st);  chk(st == 0, "R2 reset enable", 256'(st), 0);

    for (int r = 1; r < 8; r++) wreg(r, m[r]);
    rreg(1, v); chk(v == m[1], "R1 register readback r1", v, m[1]);
    rreg(6, v); chk(v == m[6], "R1 register readback r6", v, m[6]);
    wr(12'(7 * 32 + 3 * 4), 32'h0BADF00D);
    rreg(7, v); chk(v == {m[7][255:128], 32'h0BADF00D, m[7][95:0]}, "R1 single word write",
                    v, {m[7][255:128], 32'h0BADF00D, m[7][95:0]});
    wreg(7, m[7]);

    pput(0, 32'd0);
    wr(A_CTL, 32'h0000_0101);
    rd(A_STS, st); chk(st == 0, "R2 start ignored while disabled", 256'(st), 0);
    wr(A_EN, 1); rd(A_EN, st); chk(st == 1, "R2 enable readback", 256'(st), 1);

    foreach (VEC[i]) begin
      logic [5:0] op = VEC[i][22:17], a = VEC[i][16:11], b = VEC[i][10:5];
      logic [4:0] dd = VEC[i][4:0];
      wreg(int'(dd), '1);
      pput(0, enc(op, a, b, dd, 9'd0));
      pput(1, 32'd0);
      run(2, st);
      chk(st == 0, "R12 clean finish status", 256'(st), 0);
      rreg(int'(dd), v);
      chk(v == model(op, a, b), tagof(op), v, model(op, a, b));
    end

    // R5 conditional swap of r8/r9 under selector r10
    for (int s = 0; s < 2; s++) begin
      wreg(8, m[1]); wreg(9, m[2]); wreg(10, 256'(s));
      pput(0, enc(6'd2, 6'd8, 6'd9, 5'd30, 9'd0));
      pput(1, enc(6'd3, 6'd10, 6'd30, 5'd30, 9'd0));
      pput(2, enc(6'd2, 6'd30, 6'd8, 5'd8, 9'd0));
      pput(3, enc(6'd2, 6'd30, 6'd9, 5'd9, 9'd0));
      pput(4, 32'd0);
      run(5, st);
      rreg(8, v); chk(v == (s ? m[2] : m[1]), "R5 swap r8", v, s ? m[2] : m[1]);
      rreg(9, v); chk(v == (s ? m[1] : m[2]), "R5 swap r9", v, s ? m[1] : m[2]);
    end

    // R8 branch: skip the overwrite of r25 when tested operand is zero
    pput(0, enc(6'd1, 6'd37, 6'd0, 5'd25, 9'd0));
    pput(1, enc(6'd7, 6'd24, 6'd0, 5'd0, 9'd2));
    pput(2, enc(6'd1, 6'd38, 6'd0, 5'd25, 9'd0));
    pput(3, 32'd0);
    wreg(24, m[2]); run(4, st); rreg(25, v); chk(v == 10, "R8 nonzero falls through", v, 10);
    wreg(24, 0);    run(4, st); rreg(25, v); chk(v == 5, "R8 zero branches", v, 5);
    wreg(24, 256'd1 << 255); run(4, st); rreg(25, v); chk(v == 10, "R8 top bit only not zero", v, 10);
    pput(1, enc(6'd7, 6'd32, 6'd0, 5'd0, 9'd2));
    wreg(24, m[1]); run(4, st); rreg(25, v); chk(v == 5, "R8 constant 0 always branches", v, 5);

    // R9 ladder loop counting passes into r5 (r5 -= 1 per pass)
    pput(0, enc(6'd1, 6'd42, 6'd0, 5'd19, 9'd0));
    pput(1, enc(6'd1, 6'd32, 6'd0, 5'd5, 9'd0));
    pput(2, enc(6'd6, 6'd5, 6'd33, 5'd5, 9'd0));
    pput(3, enc(6'd7, 6'd19, 6'd0, 5'd0, 9'd3));
    pput(4, enc(6'd6, 6'd19, 6'd33, 5'd19, 9'd0));
    pput(5, enc(6'd7, 6'd32, 6'd0, 5'd0, 9'h1FD));
    pput(6, 32'd0);
    pput(50, 32'h0000_0ABC);
    wr(A_CTL, 32'h0000_0701);
    rd(A_STS, st); chk(st[0] == 1'b1, "R2 busy during run", 256'(st), 1);
    wr(12'(7 * 32), 32'h12345678);
    wr(A_PROG + 12'(50 * 4), 32'hDEAD0000);
    rd(12'(7 * 32), d); chk(d == m[7][31:0], "R11 read during run", 256'(d), 256'(m[7][31:0]));
    for (int n = 0; n < 5000; n++) begin
      rd(A_STS, st);
      if (!st[0]) break;
    end
    chk(st == 0, "R9 ladder clean finish", 256'(st), 0);
    rreg(5, v); chk(v == 256'd0 - 256'd255, "R9 counter 254 gives 255 passes", v, 256'd0 - 256'd255);
    rreg(19, v); chk(v == 0, "R9 counter ends at zero", v, 0);
    rreg(7, v); chk(v == m[7], "R11 register write while busy ignored", v, m[7]);
    rd(A_PROG + 12'(50 * 4), d); chk(d == 32'h0ABC, "R11 program write while busy ignored", 256'(d), 256'h0ABC);
    pput(0, enc(6'd1, 6'd32, 6'd0, 5'd19, 9'd0));
    run(7, st);
    rreg(5, v); chk(v == '1, "R9 counter 0 gives one pass", v, '1);

    // R10 overrun and undefined opcode
    pput(0, enc(6'd1, 6'd33, 6'd0, 5'd26, 9'd0));
    pput(1, enc(6'd1, 6'd33, 6'd0, 5'd27, 9'd0));
    run(2, st); chk(st == 2, "R10 overrun sets error", 256'(st), 2);
    pput(1, enc(6'd9, 6'd0, 6'd0, 5'd27, 9'd0));
    run(3, st); chk(st == 2, "R10 undefined opcode sets error", 256'(st), 2);
    pput(1, 32'd0);
    run(2, st); chk(st == 0, "R10 error cleared by next start", 256'(st), 0);

    summary();
  end
endmodule